// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Buffered Status Flags

This block receives characters from an asynchronous serial line. It uses a tick that runs at sixteen times the bit rate and is generated outside the block. Each character has one start bit, then 8 or 9 data bits sent least significant bit first, then one stop bit. When a character is complete it moves from the shift register into a single receive buffer. That buffer, and a status word, can be read by a CPU-side bus.

The block keeps three flags. The receive-complete flag says the buffer holds an unread character. The framing-error flag says the stop bit of the buffered character was sampled low. The overrun flag says a character was lost.

The overrun flag is deferred. When it happens, it is held as a pending state. It appears in the status word only when the CPU reads the valid character that is still in the buffer.

When the receiver enable is low, the receiver is held idle and no flag can be set. Flags that are already set stay as they are. An interrupt request follows the receive-complete flag, gated by a local enable and a global enable.

Top module: `serial_rx_status`

## Requirements
- R1: A frame is a low start bit, then data bits least significant first, then a stop bit, each bit lasting 16 ticks of `os_tick_i`. Each bit is decided by a majority of three samples taken near the middle of the bit, so one corrupted sample does not change it. After the frame, `data_o` holds the 8 low data bits and status bit 7 (receive complete) is 1.
- R2: In 9-bit mode (`nine_bit_i` = 1 when the start bit is seen), the ninth data bit is stored in status bit 1. In 8-bit mode status bit 1 keeps its value. After reset status bit 1 is 1.
- R3: Status bit 4 (framing error) is loaded with the inverse of the sampled stop bit each time a character enters the buffer.
- R4: A one-cycle pulse on `rd_data_i` clears status bit 7 on the next clock edge.
- R5: If a character completes while status bit 7 is 1, that character is discarded. `data_o` keeps the old character and status bit 3 (overrun) stays 0. The next `rd_data_i` pulse sets status bit 3 to 1.
- R6: Status bit 3 returns to 0 when the next character enters the buffer.
- R7: While `rx_en_i` is 0, line activity is ignored. No flag is set, no flag or data bit is cleared by the line, and the ninth bit keeps its value.
- R8: `irq_o` is 1 exactly when status bit 7, `rxc_ie_i` and `gie_i` are all 1.
- R9: A start bit whose middle three samples hold a majority of ones is treated as a false start. It is discarded without changing any output.
- R10: Status bits 6, 5, 2 and 0 always read 0.
- R11: After reset, `status_o` is 8'h02, `data_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | One-cycle pulse at 16x bit rate |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| nine_bit_i | input | 1 | 1 selects 9 data bits |
| rxc_ie_i | input | 1 | Receive-complete interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| rd_data_i | input | 1 | CPU read strobe of the data buffer |
| data_o | output | 8 | Receive buffer contents |
| status_o | output | 8 | {rxc, 0, 0, frame_err, overrun, 0, ninth_bit, 0} |
| irq_o | output | 1 | Receive-complete interrupt request |

## Verification
A stuck or wrong bit counter would show up as a wrong `data_o` value, or as a missing receive-complete flag, one stop-bit time after the frame ends. A pending overrun that is lost or shown too early can only be seen at the CPU read that follows the overrun. For that reason every overrun case checks status bit 3 both before and after that read. A wrong majority vote shows up as a changed data bit when one sample in a bit is corrupted, or as a character accepted from a short low glitch on an idle line.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import rx_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            rx_i,
  input  logic            nine_i,
  output logic            done_o,
  output logic            nine_o,
  output logic [DATA_W:0] char_o,
  output logic            stop_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] V0   = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] V1   = CNT_W'(OS_RATE / 2);
  localparam logic [CNT_W-1:0] V2   = CNT_W'(OS_RATE / 2 + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OS_RATE - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       votes_q;
  logic [DATA_W:0]  shreg_q;
  logic             nine_q, done_q, stop_q;
  logic             vote;
  logic [IDX_W-1:0] last_idx;

  assign vote     = maj3(votes_q[1], votes_q[0], rx_i);
  assign last_idx = nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      votes_q <= '1;
      shreg_q <= '0;
      nine_q  <= 1'b0;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        if (state_q == ST_IDLE) begin
          if (!rx_i) begin
            state_q <= ST_START;
            cnt_q   <= CNT_W'(1);
            nine_q  <= nine_i;
          end
        end else begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == V0 || cnt_q == V1) votes_q <= {votes_q[0], rx_i};
          if (cnt_q == V2) begin
            if (state_q == ST_START && vote) begin
              state_q <= ST_IDLE;          // false start
            end else if (state_q == ST_DATA) begin
              shreg_q[idx_q] <= vote;
            end else if (state_q == ST_STOP) begin
              done_q  <= 1'b1;
              stop_q  <= vote;
              state_q <= ST_IDLE;          // rearm at mid stop bit
            end
          end
          if (cnt_q == LAST) begin
            if (state_q == ST_START) begin
              state_q <= ST_DATA;
              idx_q   <= '0;
            end else if (state_q == ST_DATA) begin
              if (idx_q == last_idx) state_q <= ST_STOP;
              idx_q <= idx_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign done_o = done_q;
  assign nine_o = nine_q;
  assign char_o = shreg_q;
  assign stop_o = stop_q;
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              nine_i,
  input  logic [DATA_W:0]   char_i,
  input  logic              stop_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rxc_o,
  output logic              fe_o,
  output logic              ovr_o,
  output logic              b8_o
);
  logic [DATA_W-1:0] data_q;
  logic rxc_q, fe_q, ovr_q, pend_q, b8_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rxc_q  <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
      b8_q   <= 1'b1;
    end else if (done_i && (!rxc_q || rd_i)) begin
      data_q <= char_i[DATA_W-1:0];
      if (nine_i) b8_q <= char_i[DATA_W];
      fe_q   <= ~stop_i;
      rxc_q  <= 1'b1;
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (done_i) pend_q <= 1'b1;          // unread buffer: drop new char
      if (rd_i) begin
        rxc_q  <= 1'b0;
        ovr_q  <= pend_q | done_i;         // deferred overrun shows on read
        pend_q <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign rxc_o  = rxc_q;
  assign fe_o   = fe_q;
  assign ovr_o  = ovr_q;
  assign b8_o   = b8_q;
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       os_tick_i,
  input  logic       rx_i,
  input  logic       rx_en_i,
  input  logic       nine_bit_i,
  input  logic       rxc_ie_i,
  input  logic       gie_i,
  input  logic       rd_data_i,
  output logic [7:0] data_o,
  output logic [7:0] status_o,
  output logic       irq_o
);
  localparam int DATA_W = 8;

  logic            rx_s;
  logic            frame_done, frame_nine, frame_stop;
  logic [DATA_W:0] frame_char;
  logic            rxc, fe, ovr, b8;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  rx_deframer #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_deframer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rx_en_i),
    .tick_i(os_tick_i),
    .rx_i  (rx_s),
    .nine_i(nine_bit_i),
    .done_o(frame_done),
    .nine_o(frame_nine),
    .char_o(frame_char),
    .stop_o(frame_stop)
  );

  rx_buffer #(.DATA_W(DATA_W)) u_buffer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(frame_done),
    .nine_i(frame_nine),
    .char_i(frame_char),
    .stop_i(frame_stop),
    .rd_i  (rd_data_i),
    .data_o(data_o),
    .rxc_o (rxc),
    .fe_o  (fe),
    .ovr_o (ovr),
    .b8_o  (b8)
  );

  assign status_o = {rxc, 2'b00, fe, ovr, 1'b0, b8, 1'b0};
  assign irq_o    = rxc & rxc_ie_i & gie_i;
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_en_i,
  input logic       rxc_ie_i,
  input logic       gie_i,
  input logic       rd_data_i,
  input logic       frame_done,
  input logic [7:0] data_o,
  input logic [7:0] status_o,
  input logic       irq_o
);
  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o[7] && rxc_ie_i && gie_i));

  // R4
  read_clears_rxc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !frame_done) |=> !status_o[7]);

  // R1
  rxc_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[7]) |-> $past(frame_done));

  // R5
  ovr_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> $past(rd_data_i));

  // R5
  ovr_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && status_o[7] && !rd_data_i) |=> $stable(data_o));

  // R7
  disabled_no_rxc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !status_o[7]) |=> !status_o[7]);

  // R7
  disabled_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> ($stable(status_o[4]) && $stable(status_o[1]) && $stable(data_o)));
endmodule

bind serial_rx_status serial_rx_status_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_en_i   (rx_en_i),
  .rxc_ie_i  (rxc_ie_i),
  .gie_i     (gie_i),
  .rd_data_i (rd_data_i),
  .frame_done(frame_done),
  .data_o    (data_o),
  .status_o  (status_o),
  .irq_o     (irq_o)
);

// File: tb/serial_rx_status_tb.sv
module serial_rx_status_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       os_tick_i = 1'b0, rx_i = 1'b1, rx_en_i = 1'b1, nine_bit_i = 1'b0;
  logic       rxc_ie_i = 1'b0, gie_i = 1'b0, rd_data_i = 1'b0;
  logic [7:0] data_o, status_o;
  logic       irq_o;

  int total = 0, bad = 0;
  bit m_rxc, m_fe, m_ovr, m_pend, m_b8;
  logic [7:0] m_data;

  always #2 clk = ~clk;

  serial_rx_status u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .os_tick_i(os_tick_i), .rx_i(rx_i),
    .rx_en_i(rx_en_i), .nine_bit_i(nine_bit_i), .rxc_ie_i(rxc_ie_i),
    .gie_i(gie_i), .rd_data_i(rd_data_i), .data_o(data_o),
    .status_o(status_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_status();
    return {m_rxc, 2'b00, m_fe, m_ovr, 1'b0, m_b8, 1'b0};
  endfunction

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk8({tag, " data"}, data_o, m_data);
    chk8({tag, " status"}, status_o, exp_status());
    chk8({tag, " irq"}, {7'd0, irq_o}, {7'd0, m_rxc & rxc_ie_i & gie_i});
  endtask

  task automatic do_tick();
    @(negedge clk) os_tick_i = 1'b1;
    @(negedge clk) os_tick_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(logic b, int glitch);
    rx_i = b;
    for (int t = 0; t < 16; t++) begin
      rx_i = (glitch != 0 && t == 8) ? ~b : b;
      do_tick();
    end
  endtask

  task automatic model_frame(logic [8:0] ch, logic nine, logic stop);
    if (!rx_en_i) return;
    if (m_rxc) m_pend = 1'b1;
    else begin
      m_data = ch[7:0];
      if (nine) m_b8 = ch[8];
      m_fe = ~stop; m_rxc = 1'b1; m_ovr = 1'b0; m_pend = 1'b0;
    end
  endtask

  task automatic send_frame(logic [8:0] ch, logic nine, logic stop, int glitch_bit);
    nine_bit_i = nine;
    send_bit(1'b0, 0);
    for (int i = 0; i < (nine ? 9 : 8); i++) send_bit(ch[i], int'(i == glitch_bit));
    send_bit(stop, 0);
    send_bit(1'b1, 0);
    model_frame(ch, nine, stop);
  endtask

  task automatic do_read();
    @(negedge clk) rd_data_i = 1'b1;
    @(negedge clk) rd_data_i = 1'b0;
    m_rxc = 1'b0; m_ovr = m_pend; m_pend = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_rxc = 0; m_fe = 0; m_ovr = 0; m_pend = 0; m_b8 = 1; m_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk8("R11 reset status", status_o, 8'h02);
    chk8("R11 reset data", data_o, 8'h00);
    chk8("R11 reset irq", {7'd0, irq_o}, 8'h00);
    send_bit(1'b1, 0);

    send_frame(9'h0A5, 1'b0, 1'b1, -1);
    check_all("R1 8-bit frame");
    chk8("R10 unused bits", status_o & 8'h65, 8'h00);
    for (int k = 0; k < 4; k++) begin
      rxc_ie_i = k[0]; gie_i = k[1];
      @(negedge clk);
      check_all("R8 irq gating");
    end
    do_read();
    check_all("R4 read clears rxc");

    send_frame(9'h03C, 1'b1, 1'b1, -1);
    check_all("R2 ninth bit zero");
    do_read();
    send_frame(9'h15A, 1'b0, 1'b1, -1);
    check_all("R2 8-bit keeps ninth");
    do_read();
    send_frame(9'h1C3, 1'b1, 1'b1, 3);
    check_all("R1 glitch tolerated, R2 ninth set");
    do_read();

    send_frame(9'h077, 1'b0, 1'b0, -1);
    check_all("R3 stop low sets fe");
    do_read();
    send_frame(9'h088, 1'b0, 1'b1, -1);
    check_all("R3 stop high clears fe");

    send_frame(9'h0E1, 1'b0, 1'b1, -1);
    check_all("R5 overrun hidden");
    do_read();
    check_all("R5 overrun shown on read");
    send_frame(9'h0D2, 1'b0, 1'b1, -1);
    check_all("R6 overrun cleared");

    rx_en_i = 1'b0;
    send_frame(9'h13B, 1'b1, 1'b0, -1);
    check_all("R7 disabled keeps flags");
    do_read();
    send_frame(9'h044, 1'b0, 1'b1, -1);
    check_all("R7 disabled no rxc");
    rx_en_i = 1'b1;

    rx_i = 1'b0;
    for (int t = 0; t < 4; t++) do_tick();
    rx_i = 1'b1;
    for (int t = 0; t < 40; t++) do_tick();
    check_all("R9 false start ignored");

    for (int n = 0; n < 30; n++) begin
      logic [8:0] ch;
      logic nine, stop;
      ch   = 9'($urandom);
      nine = 1'($urandom);
      stop = ($urandom % 5) != 0;
      rxc_ie_i = 1'($urandom); gie_i = 1'($urandom);
      if (($urandom % 5) < 3) begin
        do_read();
        check_all("R4 random read");
      end
      send_frame(ch, nine, stop, (($urandom % 3) == 0) ? int'($urandom % 8) : -1);
      check_all("R5 random frame");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule